// File: doc/BRIEF.md
# CAN Node Bus-Join Controller

This block decides when a CAN protocol node is allowed to take part in bus traffic. It watches the sampled receive line, one sample per bit-time strobe, and counts runs of consecutive recessive bits. A node that leaves its inactive state must first see one full run of recessive bits. A node in bus-off must see a fixed number of such runs before it leaves bus-off. The protocol engine samples `participate` to gate transmission and reception. It uses `tx_cancel` to abort a frame in progress. `bus_off` reports the recovery state.

Software holds the node inactive through `init_sw`. A debug suspend request, when enabled, can also hold it inactive. The suspend request acts only once the bus is idle or the node is bus-off, and it does not touch the software bit. Bus-off recovery always runs to its end, whatever software does with `init_sw` while it runs. The run length and the number of runs for recovery are parameters, with defaults of 11 and 128.

Top module: `can_join_ctrl`

## Requirements
- R1: After reset, `participate`, `bus_off` and `tx_cancel` are all 0.
- R2: While the effective init (`init_sw` OR a latched suspend) is 1, `participate` is 0 in the same cycle.
- R3: With effective init 0 and not bus-off, `participate` becomes 1 on the clock edge of the 11th consecutive strobe with `rx_bit`=1 (recessive). A strobe with `rx_bit`=0 restarts the count. The count is held at zero while effective init is 1.
- R4: `tx_cancel` is a one-cycle combinational pulse. It is 1 in the cycle where effective init goes from 0 to 1, and only if `frame_active` is 1.
- R5: On a clock edge with `busoff_enter`=1, `bus_off` becomes 1 and `participate` becomes 0. Both the run count and the recovery count are reset.
- R6: `bus_off` returns to 0 on the edge of the strobe that completes the 128th run of 11 recessive bits. A continuous recessive stretch counts one run for every 11 bits.
- R7: Bus-off recovery counting is neither stopped nor restarted by changes of `init_sw`.
- R8: If effective init is 1 when recovery ends, `bus_off` goes to 0 and `participate` stays 0. Once init is cleared, the node needs 11 more recessive bits to join.
- R9: If effective init is 0 when recovery ends, `participate` becomes 1 on the same edge that clears `bus_off`.
- R10: With `susp_en`=1 and `susp_trig`=1, the suspend latches on the next edge where `bus_idle`=1 or the node is bus-off. It does not latch before that.
- R11: A latched suspend stays latched until `susp_trig` or `susp_en` drops. After it releases, 11 recessive bits are needed before `participate` returns to 1.
- R12: With `susp_en`=0, `susp_trig` has no effect on `participate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One pulse per bit time; `rx_bit` is valid with it |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| busoff_enter | input | 1 | Pulse from error counting: node enters bus-off |
| init_sw | input | 1 | Software inactive request |
| susp_en | input | 1 | Allow debug suspend to act |
| susp_trig | input | 1 | Debug suspend request |
| bus_idle | input | 1 | Bus is idle between frames |
| frame_active | input | 1 | A frame transfer is in progress |
| participate | output | 1 | Node may take part in bus traffic |
| tx_cancel | output | 1 | One-cycle request to abort the current frame |
| bus_off | output | 1 | Node is in bus-off |

## Verification
The bench targets the boundary of each recessive run. One dominant bit after ten recessive ones must restart the count, so a design that only counts recessive bits would join early. Recovery is fed as one unbroken recessive stretch. This exposes a design that counts a long stretch as a single run and never leaves bus-off, and one that is off by a single run. `init_sw` is toggled in the middle of recovery to catch a design that restarts or stalls recovery on init. The suspend sequence checks three things: the trigger must wait for bus idle, it must have no effect while disabled, and release must require a fresh run of recessive bits. A design that rejoins at once would raise `participate` too early.

// File: rtl/can_join_ctrl.sv
module can_join_ctrl #(
  parameter int RUN_LEN    = 11,
  parameter int RECOV_SEQS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_bit,
  input  logic busoff_enter,
  input  logic init_sw,
  input  logic susp_en,
  input  logic susp_trig,
  input  logic bus_idle,
  input  logic frame_active,
  output logic participate,
  output logic tx_cancel,
  output logic bus_off
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int SEQ_W = $clog2(RECOV_SEQS);

  logic [RUN_W-1:0] run_cnt;
  logic [SEQ_W-1:0] seq_cnt;
  logic             part_q, susp_q, eff_q, boff_q;

  wire eff_init = init_sw | susp_q;
  wire run_done = bit_stb & rx_bit & (run_cnt == RUN_W'(RUN_LEN - 1));
  wire recov_end = boff_q & run_done & (seq_cnt == SEQ_W'(RECOV_SEQS - 1));

  assign participate = part_q & ~eff_init;
  assign tx_cancel   = eff_init & ~eff_q & frame_active;
  assign bus_off     = boff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (busoff_enter || (!boff_q && eff_init)) begin
      run_cnt <= '0;
    end else if (bit_stb) begin
      if (!rx_bit || run_done) run_cnt <= '0;
      else                     run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boff_q  <= 1'b0;
      seq_cnt <= '0;
    end else if (busoff_enter) begin
      boff_q  <= 1'b1;
      seq_cnt <= '0;
    end else if (boff_q && run_done) begin
      if (recov_end) begin
        boff_q  <= 1'b0;
        seq_cnt <= '0;
      end else begin
        seq_cnt <= seq_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= 1'b0;
    end else if (busoff_enter || eff_init) begin
      part_q <= 1'b0;
    end else if (boff_q) begin
      part_q <= recov_end;
    end else if (run_done) begin
      part_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      eff_q  <= 1'b1;
    end else begin
      susp_q <= susp_en & susp_trig & (susp_q | bus_idle | boff_q);
      eff_q  <= eff_init;
    end
  end
endmodule

module can_join_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busoff_enter,
  input logic init_sw,
  input logic frame_active,
  input logic participate,
  input logic tx_cancel,
  input logic bus_off
);
  assert_init_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_sw |-> !participate);
  assert_cancel_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cancel |=> !tx_cancel);
  assert_cancel_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cancel |-> frame_active);
  assert_busoff_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_enter |=> (bus_off && !participate));
  assert_busoff_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> !participate);
endmodule

bind can_join_ctrl can_join_ctrl_chk u_chk (.*);

// File: tb/tb_can_join_ctrl.sv
module tb_can_join_ctrl;
  logic clk = 0, rst_n = 0;
  logic bit_stb = 0, rx_bit = 1, busoff_enter = 0, init_sw = 1;
  logic susp_en = 0, susp_trig = 0, bus_idle = 0, frame_active = 0;
  logic participate, tx_cancel, bus_off;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_join_ctrl dut (.*);

  int m_run = 0, m_seq = 0;
  bit m_boff = 0, m_part = 0, m_susp = 0, m_effq = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_seq = 0; m_boff = 0; m_part = 0; m_susp = 0; m_effq = 1;
    end else begin
      bit eff, full, last;
      eff  = init_sw | m_susp;
      full = bit_stb && rx_bit && (m_run == 10);
      last = full && m_boff && (m_seq == 127);
      if (busoff_enter) m_part = 0;
      else if (eff) m_part = 0;
      else if (m_boff) m_part = last;
      else if (full) m_part = 1;
      if (busoff_enter || (!m_boff && eff)) m_run = 0;
      else if (bit_stb) m_run = (!rx_bit || full) ? 0 : m_run + 1;
      if (busoff_enter) begin m_boff = 1; m_seq = 0; end
      else if (m_boff && full) begin
        if (last) begin m_boff = 0; m_seq = 0; end
        else m_seq++;
      end
      m_susp = susp_en && susp_trig && (m_susp || bus_idle || m_boff);
      m_effq = eff;
      cycles++;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    bit eff;
    eff = init_sw | m_susp;
    chk("R2/R3 participate model", participate, m_part & ~eff);
    chk("R5/R6 bus_off model", bus_off, m_boff);
    chk("R4 tx_cancel model", tx_cancel, eff & ~m_effq & frame_active);
  endtask

  task automatic tick();
    @(posedge clk); #2;
    compare_model();
  endtask

  task automatic send(int n, logic v);
    for (int i = 0; i < n; i++) begin
      rx_bit = v; bit_stb = 1; tick();
    end
    bit_stb = 0; rx_bit = 1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 100000 && !done) begin
    done = 1; failures++;
    $display("FAIL watchdog actual=%0d expected<100000", cycles);
    finish_run();
  end

  initial begin
    #20; @(negedge clk);
    chk("R1 participate", participate, 0);
    chk("R1 bus_off", bus_off, 0);
    chk("R1 tx_cancel", tx_cancel, 0);
    rst_n = 1;
    tick();
    send(20, 1);
    chk("R2 held by init", participate, 0);
    init_sw = 0;
    send(10, 1); send(1, 0); send(10, 1);
    chk("R3 dominant restarts run", participate, 0);
    send(1, 1);
    chk("R3 joined after 11", participate, 1);
    frame_active = 1; init_sw = 1; #1;
    chk("R4 cancel pulse", tx_cancel, 1);
    chk("R2 immediate block", participate, 0);
    tick();
    chk("R4 pulse one cycle", tx_cancel, 0);
    init_sw = 0; tick(); frame_active = 0; init_sw = 1; #1;
    chk("R4 no pulse without frame", tx_cancel, 0);
    tick(); init_sw = 0;
    send(11, 1);
    chk("R3 rejoin", participate, 1);
    busoff_enter = 1; tick(); busoff_enter = 0;
    chk("R5 bus_off set", bus_off, 1);
    chk("R5 participation dropped", participate, 0);
    for (int i = 0; i < 128 * 11 - 1; i++) begin
      if (i == 300) init_sw = 1;
      if (i == 700) init_sw = 0;
      send(1, 1);
    end
    chk("R6 still bus_off one bit short", bus_off, 1);
    chk("R7 recovery unaffected by init", bus_off, 1);
    send(1, 1);
    chk("R6 recovery complete", bus_off, 0);
    chk("R9 join at recovery end", participate, 1);
    init_sw = 1; busoff_enter = 1; tick(); busoff_enter = 0;
    send(128 * 11, 1);
    chk("R8 left bus_off", bus_off, 0);
    chk("R8 stays inactive", participate, 0);
    init_sw = 0;
    send(10, 1);
    chk("R8 needs fresh run", participate, 0);
    send(1, 1);
    chk("R8 joined", participate, 1);
    susp_trig = 1; bus_idle = 1;
    repeat (3) tick();
    chk("R12 suspend disabled ignored", participate, 1);
    susp_en = 1; bus_idle = 0;
    repeat (3) tick();
    chk("R10 waits for bus idle", participate, 1);
    bus_idle = 1; tick();
    chk("R10 forced inactive", participate, 0);
    chk("R10 bus_off untouched", bus_off, 0);
    bus_idle = 0; repeat (3) tick();
    chk("R11 latched", participate, 0);
    susp_trig = 0; tick();
    send(10, 1);
    chk("R11 needs fresh run", participate, 0);
    send(1, 1);
    chk("R11 rejoined", participate, 1);
    repeat (4) tick();
    done = 1;
    finish_run();
  end
endmodule